// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host hands it one request at a time over a valid/ready handshake: a read/write flag, a 17-bit address and, for writes, a byte of data. The controller turns each request into a strobe sequence for the memory. It drives an active-low select, an active-high select, an active-low write strobe and an active-low output strobe. It also drives the address and a data bus split into an output value, an output-enable for the pad and an input value. When a read completes, the returned byte comes back with a one-cycle completion pulse.

Each timing figure of the memory is a parameter in nanoseconds. The controller rounds each one up to whole clock cycles. A write is opened and closed by the write strobe and both selects together. The output strobe stays high for the whole write. A bus turnaround interval, long enough for the memory to float its outputs, separates any write from a read and any read from a write. Between requests both selects sit in their standby levels.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is 1, the pins are in standby: `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0. `req_ready` is 1 after reset.
- R2: A write is accepted on a clock edge where `req_valid` and `req_ready` are both 1 and `req_write`=1. For the next N_WP cycles the pins are `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, with `mem_addr` and `mem_dq_out` equal to the accepted address and data. N_WP is the largest of ceil(T_WP/CLK), ceil(T_AW/CLK) and ceil(T_DS/CLK), which is 5 at the defaults.
- R3: After the write pulse, the selects go to standby and `mem_we_n`=1 in the same cycle. The data stays driven for max(ceil(T_CYC/CLK)-N_WP, 1) cycles, which is 1 at the defaults. The bus is then released.
- R4: A read (`req_write`=0) is accepted on the same handshake. For the next N_RD cycles the pins are `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=1, `mem_oe_n`=0 and `mem_dq_oe`=0. N_RD is the largest of the cycle, address-access and output-enable times in cycles, which is 6 at the defaults.
- R5: `rsp_rdata` takes the value of `mem_dq_in` on the last cycle of the read window and holds it until the next read.
- R6: Every access ends with N_TA=ceil(T_HZ/CLK) cycles (2 at the defaults) with all pins in standby while `req_ready` is still 0. `mem_oe_n` never falls fewer than N_TA cycles after `mem_dq_oe` was last 1, and `mem_dq_oe` never rises fewer than N_TA cycles after `mem_oe_n` was last 0.
- R7: `req_ready` is 0 from the cycle after acceptance until the access, including its recovery, is over. That is 8 cycles for a write and 8 for a read at the defaults. `rsp_done` is 1 for exactly the first cycle in which `req_ready` is back at 1.
- R8: `mem_oe_n` is never 0 while `mem_we_n` is 0 or while `mem_dq_oe` is 1.
- R9: `mem_addr` does not change while `mem_sel_n` is 0.
- R10: `req_valid` while `req_ready` is 0 has no effect: no extra access is started and no memory location is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Pad output-enable for the data bus |
| mem_dq_in | input | 8 | Data seen on the bus from memory |

## Verification
The bench attaches a behavioural memory that returns a poison byte until a read has been open for the full access time. A controller that samples one cycle early therefore reads the poison byte instead of the stored value. The memory model also rejects write pulses shorter than the rounded pulse width, so a shortened strobe loses the store and fails the read-back. Write-then-read and read-then-write pairs at address 0 and at the top address check the bus turnaround: a design that lowers the output strobe too early is caught both by the cycle-by-cycle reference and by the model's contention check. A request held valid while the controller is busy, carrying a write to an unrelated address, must leave that location at its default contents; a design that accepts it would show an extra strobe sequence and a corrupted read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE       = 3'd0,
    SEQ_WR_PULSE   = 3'd1,
    SEQ_WR_HOLD    = 3'd2,
    SEQ_TURN       = 3'd3,
    SEQ_RD_ACCESS  = 3'd4,
    SEQ_RD_RELEASE = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
    logic drive;
  } pin_set_t;

  localparam pin_set_t PINS_STANDBY = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // strobe levels belonging to each sequencer state
  function automatic pin_set_t pins_for(input seq_state_t s);
    pin_set_t p;
    p = PINS_STANDBY;
    case (s)
      SEQ_WR_PULSE: begin
        p.sel_n = 1'b0; p.sel = 1'b1; p.we_n = 1'b0; p.drive = 1'b1;
      end
      SEQ_WR_HOLD:  p.drive = 1'b1;
      SEQ_RD_ACCESS: begin
        p.sel_n = 1'b0; p.sel = 1'b1; p.oe_n = 1'b0;
      end
      default: p = PINS_STANDBY;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_span_counter.sv
module sram_span_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_WP    = 5,
  parameter int unsigned N_WHOLD = 1,
  parameter int unsigned N_TA    = 2,
  parameter int unsigned N_RD    = 6,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic             span_done,
  output seq_state_t       state_q,
  output seq_state_t       state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  localparam logic [CNT_W-1:0] LV_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LV_WH = CNT_W'(N_WHOLD - 1);
  localparam logic [CNT_W-1:0] LV_TA = CNT_W'(N_TA - 1);
  localparam logic [CNT_W-1:0] LV_RD = CNT_W'(N_RD - 1);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      SEQ_IDLE: if (start) begin
        load = 1'b1;
        if (start_wr) begin state_d = SEQ_WR_PULSE;  load_val = LV_WP; end
        else          begin state_d = SEQ_RD_ACCESS; load_val = LV_RD; end
      end
      SEQ_WR_PULSE: if (span_done) begin
        state_d = SEQ_WR_HOLD; load = 1'b1; load_val = LV_WH;
      end
      SEQ_WR_HOLD: if (span_done) begin
        state_d = SEQ_TURN; load = 1'b1; load_val = LV_TA;
      end
      SEQ_RD_ACCESS: if (span_done) begin
        state_d = SEQ_RD_RELEASE; load = 1'b1; load_val = LV_TA;
      end
      SEQ_TURN, SEQ_RD_RELEASE: if (span_done) state_d = SEQ_IDLE;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state_d,
  output pin_set_t   pins_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_STANDBY;
    else        pins_q <= pins_for(state_d);
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_CYC_NS = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_OE_NS  = 30,
  parameter int unsigned T_WP_NS  = 45,
  parameter int unsigned T_AW_NS  = 50,
  parameter int unsigned T_DS_NS  = 25,
  parameter int unsigned T_HZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned C_CYC  = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int unsigned N_WP   = max_u(ns_to_cyc(T_WP_NS, CLK_NS),
                                         max_u(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)));
  localparam int unsigned N_RD   = max_u(C_CYC,
                                         max_u(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int unsigned N_WHOLD = (C_CYC > N_WP) ? (C_CYC - N_WP) : 1;
  localparam int unsigned N_TA   = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned N_MAX  = max_u(max_u(N_WP, N_RD), max_u(N_WHOLD, N_TA));
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

  seq_state_t       state_q, state_d;
  logic             accept, sample_now, finish_now;
  logic             span_load, span_done;
  logic [CNT_W-1:0] span_val;
  pin_set_t         pins_q;

  assign req_ready  = (state_q == SEQ_IDLE);
  assign accept     = req_valid && req_ready;
  assign sample_now = (state_q == SEQ_RD_ACCESS) && span_done;
  assign finish_now = (state_q != SEQ_IDLE) && (state_d == SEQ_IDLE);

  sram_seq_fsm #(
    .N_WP(N_WP), .N_WHOLD(N_WHOLD), .N_TA(N_TA), .N_RD(N_RD), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .span_done(span_done), .state_q(state_q), .state_d(state_d),
    .load(span_load), .load_val(span_val)
  );

  sram_span_counter #(.W(CNT_W)) u_span (
    .clk(clk), .rst_n(rst_n), .load(span_load), .load_val(span_val), .zero(span_done)
  );

  sram_pin_reg u_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .pins_q(pins_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= finish_now;
      if (sample_now) rsp_rdata <= mem_dq_in;
    end
  end

  assign mem_sel_n = pins_q.sel_n;
  assign mem_sel   = pins_q.sel;
  assign mem_we_n  = pins_q.we_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_dq_oe = pins_q.drive;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned N_WP   = 5,
  parameter int unsigned N_TA   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  logic [7:0] we_low_cnt, bus_free_cnt, oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt   <= '0;
      bus_free_cnt <= '1;
      oe_high_cnt  <= '1;
    end else begin
      if (!mem_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
      else           we_low_cnt <= '0;
      if (!mem_dq_oe) bus_free_cnt <= (bus_free_cnt == 8'hFF) ? bus_free_cnt : bus_free_cnt + 8'd1;
      else            bus_free_cnt <= '0;
      if (mem_oe_n) oe_high_cnt <= (oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 8'd1;
      else          oe_high_cnt <= '0;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_low_cnt) >= N_WP)); // R2
  AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (32'(bus_free_cnt) >= N_TA)); // R6
  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (32'(oe_high_cnt) >= N_TA)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R7
  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R8
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr)); // R9
endmodule

bind sram_strobe_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W), .N_WP(N_WP), .N_TA(N_TA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WP_CYC  = 5;   // 45 ns, 50 ns, 25 ns rounded up to 10 ns steps, largest
  localparam int RD_CYC  = 6;   // 55 ns rounded up
  localparam int WH_CYC  = 1;   // 6 - 5
  localparam int TA_CYC  = 2;   // 20 ns rounded up
  localparam int WATCHDOG = 20000;
  localparam int K_IDLE = 0, K_BUSY = 1, K_WP = 2, K_WH = 3, K_RD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [16:0] mem_addr;
  logic mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] mem_dq_in = 8'hEE;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  bit done_pending = 0;
  logic [16:0] cur_addr = '0;
  logic [7:0]  cur_data = '0;
  logic [7:0] model_mem [int];
  logic [7:0] exp_mem [int];
  int rd_seen = 0, wr_seen = 0, free_prior = 100;
  logic prev_oe_n = 1'b1;
  logic [16:0] w_addr = '0;
  logic [7:0]  w_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model and memory model, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      bit exp_done;
      logic [5:0] exp_pins;
      string tag;
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        finish_run();
      end
      exp_done = done_pending;
      done_pending = 0;
      if (exp_q.size() > 0) begin
        kind = exp_q.pop_front();
        if (exp_q.size() == 0) done_pending = 1;
      end else kind = K_IDLE;
      // {ready, sel_n, sel, we_n, oe_n, dq_oe}
      case (kind)
        K_WP:    begin exp_pins = 6'b0_01_0_1_1; tag = "R2"; end
        K_WH:    begin exp_pins = 6'b0_10_1_1_1; tag = "R3"; end
        K_RD:    begin exp_pins = 6'b0_01_1_0_0; tag = "R4"; end
        K_BUSY:  begin exp_pins = 6'b0_10_1_1_0; tag = "R6"; end
        default: begin exp_pins = 6'b1_10_1_1_0; tag = "R1"; end
      endcase
      chk(tag, "pins{rdy,seln,sel,wen,oen,drv}",
          {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, exp_pins);
      chk("R7", "rsp_done", rsp_done, exp_done);
      if (kind == K_WP || kind == K_RD) chk("R9", "mem_addr", mem_addr, cur_addr);
      if (kind == K_WP || kind == K_WH) chk("R2", "mem_dq_out", mem_dq_out, cur_data);

      // request acceptance predicted from the model's own ready (R10)
      if (kind == K_IDLE && req_valid) begin
        cur_addr = req_addr;
        cur_data = req_wdata;
        if (req_write) begin
          for (int i = 0; i < WP_CYC; i++) exp_q.push_back(K_WP);
          for (int i = 0; i < WH_CYC; i++) exp_q.push_back(K_WH);
        end else begin
          for (int i = 0; i < RD_CYC; i++) exp_q.push_back(K_RD);
        end
        for (int i = 0; i < TA_CYC; i++) exp_q.push_back(K_BUSY);
      end

      // memory model: contention, turnaround, write pulse, read data
      if (!mem_oe_n && mem_dq_oe) chk("R8", "bus contention", 1, 0);
      if (prev_oe_n && !mem_oe_n && free_prior < TA_CYC) chk("R6", "turnaround cycles", free_prior, TA_CYC);
      free_prior = mem_dq_oe ? 0 : free_prior + 1;
      prev_oe_n = mem_oe_n;
      if (!mem_sel_n && mem_sel && !mem_we_n) begin
        wr_seen++;
        w_addr = mem_addr;
        w_data = mem_dq_out;
      end else if (wr_seen > 0) begin
        if (wr_seen >= WP_CYC) model_mem[int'(w_addr)] = w_data;
        else chk("R2", "write pulse cycles", wr_seen, WP_CYC);
        wr_seen = 0;
      end
      if (!mem_sel_n && mem_sel && mem_we_n && !mem_oe_n) rd_seen++;
      else rd_seen = 0;
      if (rd_seen >= RD_CYC)
        mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : dflt(mem_addr);
      else
        mem_dq_in = 8'hEE;
    end
  end

  task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input bit garbage, input string req);
    bit acc;
    logic [7:0] expv;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin @(negedge clk); acc = req_ready; end while (!acc);
    @(posedge clk); #1;
    if (garbage) begin
      req_write = 1'b1; req_addr = 17'h0BEEF; req_wdata = 8'h77;
      repeat (4) @(posedge clk);
      #1;
    end
    req_valid = 1'b0;
    do @(negedge clk); while (!rsp_done);
    if (wr) exp_mem[int'(a)] = d;
    else begin
      expv = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
      chk(req, "rsp_rdata", rsp_rdata, expv);
    end
  endtask

  initial begin
    logic [16:0] lf;
    repeat (3) @(negedge clk);
    chk("R1", "reset pins{rdy,seln,sel,wen,oen,drv}",
        {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b1_10_1_1_0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    run_op(1, 17'h00000, 8'h5A, 0, "R5");
    run_op(0, 17'h00000, 8'h00, 0, "R5");       // write then read, address 0
    run_op(1, 17'h1FFFF, 8'hA5, 0, "R5");
    run_op(0, 17'h1FFFF, 8'h00, 0, "R5");       // top address
    run_op(0, 17'h00000, 8'h00, 0, "R5");       // read then read
    run_op(1, 17'h00100, 8'h33, 1, "R10");      // valid held while busy
    run_op(0, 17'h0BEEF, 8'h00, 0, "R10");      // must still hold default
    run_op(0, 17'h00100, 8'h00, 0, "R10");
    run_op(1, 17'h00000, 8'hC3, 0, "R3");       // overwrite
    run_op(0, 17'h00000, 8'h00, 0, "R3");
    run_op(0, 17'h12345, 8'h00, 0, "R5");       // never written
    lf = 17'h1ACE1;
    for (int i = 0; i < 16; i++) begin
      lf = {lf[15:0], lf[16] ^ lf[13]};
      run_op(1, lf, lf[7:0] ^ 8'h96, 0, "R2");
      run_op(0, lf, 8'h00, 0, "R4");
    end
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule